// File: doc/BRIEF.md
# Next Fetch Address Resolver

This block computes the address of the instruction that follows the current one in a 32-bit RISC core whose instructions are one word each. It takes the current program counter and the fetched instruction word. It returns the two source register indices encoded in that word. The register file answers with their values, and the block decides the successor address in the same cycle. Conditional branches compare the two register values under one of ten signed or unsigned relations. Relative jumps add a scaled 26-bit offset. Register jumps take the first register's value with the byte-offset bits cleared.

One opcode has no successor that the block can work out. For that opcode it raises a flag and still offers the sequential address. A registered copy of the successor address is kept for a fetch stage. It loads on an advance strobe and resets to a configurable vector.

Top module: `npc_resolve`

## Requirements
- R1: `rs_idx_o` equals instruction bits 25:21 and `rt_idx_o` equals bits 20:16. The opcode is bits 31:26, the branch immediate is bits 15:0 and the jump offset is bits 25:0.
- R2: Opcodes 0x20 to 0x29 are conditional branches. The relation used is selected by the opcode minus 0x20, and the first operand is always compared against the second. The order is: 0 equal, 1 not equal, 2 signed less-or-equal, 3 unsigned less-or-equal, 4 signed less, 5 unsigned less, 6 signed greater-or-equal, 7 unsigned greater-or-equal, 8 signed greater, 9 unsigned greater.
- R3: When the condition of a branch holds, `next_pc_o` is PC+4 plus the sign-extended 16-bit immediate shifted left by two. When it does not hold, `next_pc_o` is PC+4.
- R4: Opcodes 0x2A and 0x2C give PC+4 plus the sign-extended 26-bit offset shifted left by two.
- R5: Opcodes 0x2B and 0x2D give the first operand with bits 1:0 forced to zero.
- R6: Opcode 0x2E and every opcode in 0x00 to 0x1F and 0x30 to 0x3F give PC+4.
- R7: Opcode 0x2F drives `unresolved_o` high and `next_pc_o` to PC+4. `unresolved_o` is low for every other opcode.
- R8: A register index of 0 yields a zero operand, whatever value is presented on the matching value input.
- R9: `taken_o` is high for the four jump opcodes and for conditional branches whose condition holds. It is low otherwise.
- R10: All address sums wrap modulo 2^32.
- R11: `pc_q_o` is set to `RESET_VEC` while `rst_n` is low, independently of the clock. On a rising clock edge it loads `next_pc_o` when `advance_i` is high, and it holds its value when `advance_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered address |
| rst_n | input | 1 | Asynchronous active-low reset |
| advance_i | input | 1 | Load enable for `pc_q_o` |
| pc_i | input | 32 | Address of the current instruction |
| instr_i | input | 32 | Current instruction word |
| rs_idx_o | output | 5 | First source register index |
| rt_idx_o | output | 5 | Second source register index |
| rs_val_i | input | 32 | Value of register `rs_idx_o` |
| rt_val_i | input | 32 | Value of register `rt_idx_o` |
| next_pc_o | output | 32 | Combinational successor address |
| taken_o | output | 1 | Branch taken or jump |
| unresolved_o | output | 1 | Successor cannot be determined |
| pc_q_o | output | 32 | Registered successor address |

## Verification
The bench builds the block with `RESET_VEC` set to 0x0000_0100. This non-zero vector makes a missing or wrong reset value visible as an observable difference, rather than blending into an all-zero register.

The register values come from a small array in the bench that is indexed by the block's own index outputs. Entry 0 of that array holds a non-zero pattern, so any failure to force a zero operand changes the branch and jump results.

The operand pairs are chosen to straddle the sign bit, so the signed and unsigned relations disagree. The program counters sit near the top of the address space, which brings wrap-around within reach.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int XLEN      = 32;
  localparam int OP_W      = 6;
  localparam int RIDX_W    = 5;
  localparam int IMM_W     = 16;
  localparam int OFF_W     = 26;
  localparam int COND_W    = 4;
  localparam int N_COND    = 10;
  localparam int INSTR_B   = 4;
  localparam int ALIGN_W   = 2;

  localparam logic [1:0] GRP_CTRL = 2'b10;

  typedef enum logic [2:0] {
    NPC_SEQ,
    NPC_BRANCH,
    NPC_JREL,
    NPC_JREG,
    NPC_STOP
  } npc_kind_e;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [XLEN-1:0]   instr_i,
  output npc_kind_e         kind_o,
  output logic [COND_W-1:0] cond_o,
  output logic [RIDX_W-1:0] rs_idx_o,
  output logic [RIDX_W-1:0] rt_idx_o,
  output logic [IMM_W-1:0]  imm_o,
  output logic [OFF_W-1:0]  off_o
);
  localparam int OP_LSB = XLEN - OP_W;
  localparam int RS_LSB = OP_LSB - RIDX_W;
  localparam int RT_LSB = RS_LSB - RIDX_W;

  logic [OP_W-1:0] op;
  logic [3:0]      sub;

  always_comb begin
    op       = instr_i[XLEN-1:OP_LSB];
    sub      = op[3:0];
    rs_idx_o = instr_i[OP_LSB-1:RS_LSB];
    rt_idx_o = instr_i[RS_LSB-1:RT_LSB];
    imm_o    = instr_i[IMM_W-1:0];
    off_o    = instr_i[OFF_W-1:0];
    cond_o   = sub;
    kind_o   = NPC_SEQ;
    if (op[5:4] == GRP_CTRL) begin
      if (sub < COND_W'(N_COND)) begin
        kind_o = NPC_BRANCH;
      end else begin
        unique case (sub)
          4'hA, 4'hC: kind_o = NPC_JREL;
          4'hB, 4'hD: kind_o = NPC_JREG;
          4'hF:       kind_o = NPC_STOP;
          default:    kind_o = NPC_SEQ;
        endcase
      end
    end
  end
endmodule

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
(
  input  logic [COND_W-1:0] cond_i,
  input  logic [XLEN-1:0]   a_i,
  input  logic [XLEN-1:0]   b_i,
  output logic              hit_o
);
  logic eq, slt, ult;

  always_comb begin
    eq  = (a_i == b_i);
    slt = ($signed(a_i) < $signed(b_i));
    ult = (a_i < b_i);
    unique case (cond_i)
      4'd0:    hit_o = eq;
      4'd1:    hit_o = !eq;
      4'd2:    hit_o = slt || eq;
      4'd3:    hit_o = ult || eq;
      4'd4:    hit_o = slt;
      4'd5:    hit_o = ult;
      4'd6:    hit_o = !slt;
      4'd7:    hit_o = !ult;
      4'd8:    hit_o = !slt && !eq;
      4'd9:    hit_o = !ult && !eq;
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
(
  input  npc_kind_e        kind_i,
  input  logic             hit_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  rs_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [XLEN-1:0]  next_o,
  output logic             taken_o
);
  localparam int IMM_PAD = XLEN - IMM_W - ALIGN_W;
  localparam int OFF_PAD = XLEN - OFF_W - ALIGN_W;

  logic [XLEN-1:0] seq, br_tgt, jr_tgt, reg_tgt;

  always_comb begin
    seq     = pc_i + XLEN'(INSTR_B);
    br_tgt  = seq + {{IMM_PAD{imm_i[IMM_W-1]}}, imm_i, {ALIGN_W{1'b0}}};
    jr_tgt  = seq + {{OFF_PAD{off_i[OFF_W-1]}}, off_i, {ALIGN_W{1'b0}}};
    reg_tgt = {rs_i[XLEN-1:ALIGN_W], {ALIGN_W{1'b0}}};
    next_o  = seq;
    taken_o = 1'b0;
    unique case (kind_i)
      NPC_BRANCH: begin
        if (hit_i) begin
          next_o  = br_tgt;
          taken_o = 1'b1;
        end
      end
      NPC_JREL: begin
        next_o  = jr_tgt;
        taken_o = 1'b1;
      end
      NPC_JREG: begin
        next_o  = reg_tgt;
        taken_o = 1'b1;
      end
      default: begin
        next_o  = seq;
        taken_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/npc_resolve.sv
module npc_resolve
  import npc_pkg::*;
#(
  parameter logic [31:0] RESET_VEC = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        advance_i,
  input  logic [31:0] pc_i,
  input  logic [31:0] instr_i,
  output logic [4:0]  rs_idx_o,
  output logic [4:0]  rt_idx_o,
  input  logic [31:0] rs_val_i,
  input  logic [31:0] rt_val_i,
  output logic [31:0] next_pc_o,
  output logic        taken_o,
  output logic        unresolved_o,
  output logic [31:0] pc_q_o
);
  npc_kind_e         kind;
  logic [COND_W-1:0] cond;
  logic [IMM_W-1:0]  imm;
  logic [OFF_W-1:0]  off;
  logic [XLEN-1:0]   rs_op, rt_op;
  logic              hit;
  logic [XLEN-1:0]   pc_d, pc_q;

  npc_decode u_decode (
    .instr_i  (instr_i),
    .kind_o   (kind),
    .cond_o   (cond),
    .rs_idx_o (rs_idx_o),
    .rt_idx_o (rt_idx_o),
    .imm_o    (imm),
    .off_o    (off)
  );

  // register 0 never contributes a value
  always_comb begin
    rs_op = (rs_idx_o == '0) ? '0 : rs_val_i;
    rt_op = (rt_idx_o == '0) ? '0 : rt_val_i;
  end

  npc_cond u_cond (
    .cond_i (cond),
    .a_i    (rs_op),
    .b_i    (rt_op),
    .hit_o  (hit)
  );

  npc_target u_target (
    .kind_i  (kind),
    .hit_i   (hit),
    .pc_i    (pc_i),
    .rs_i    (rs_op),
    .imm_i   (imm),
    .off_i   (off),
    .next_o  (next_pc_o),
    .taken_o (taken_o)
  );

  assign unresolved_o = (kind == NPC_STOP);

  always_comb begin
    pc_d = pc_q;
    if (advance_i) begin
      pc_d = next_pc_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= RESET_VEC;
    end else begin
      pc_q <= pc_d;
    end
  end

  assign pc_q_o = pc_q;

  // R7
  unres_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unresolved_o |-> (next_pc_o == pc_i + 32'd4) && !taken_o);

  // R9
  idle_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !taken_o |-> next_pc_o == pc_i + 32'd4);

  // R5
  jreg_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == NPC_JREG) |-> next_pc_o[1:0] == 2'b00);

  // R11
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    advance_i |=> pc_q_o == $past(next_pc_o));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !advance_i |=> $stable(pc_q_o));
endmodule

// File: tb/test_npc_resolve.sv
module test_npc_resolve;
  localparam logic [31:0] RV = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst_n, advance;
  logic [31:0] pc, instr, rs_val, rt_val, next_pc, pc_q;
  logic [4:0]  rs_idx, rt_idx;
  logic        taken, unres;
  logic [31:0] regs [32];
  int          n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  always_comb begin
    rs_val = regs[rs_idx];
    rt_val = regs[rt_idx];
  end

  npc_resolve #(.RESET_VEC(RV)) i_npc_resolve (
    .clk(clk), .rst_n(rst_n), .advance_i(advance), .pc_i(pc), .instr_i(instr),
    .rs_idx_o(rs_idx), .rt_idx_o(rt_idx), .rs_val_i(rs_val), .rt_val_i(rt_val),
    .next_pc_o(next_pc), .taken_o(taken), .unresolved_o(unres), .pc_q_o(pc_q)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_i(input logic [5:0] op, input logic [4:0] a,
                                       input logic [4:0] b, input logic [15:0] imm);
    return {op, a, b, imm};
  endfunction

  function automatic logic [31:0] mk_j(input logic [5:0] op, input logic [25:0] off);
    return {op, off};
  endfunction

  function automatic logic ref_cond(input int c, input logic [31:0] a, input logic [31:0] b);
    int signed sa = a;
    int signed sb = b;
    case (c)
      0: return a == b;
      1: return a != b;
      2: return sa <= sb;
      3: return a <= b;
      4: return sa < sb;
      5: return a < b;
      6: return sa >= sb;
      7: return a >= b;
      8: return sa > sb;
      default: return a > b;
    endcase
  endfunction

  task automatic drive(input logic [31:0] p, input logic [31:0] i);
    @(negedge clk);
    pc = p;
    instr = i;
    #1;
  endtask

  task automatic t_reset;
    chk("R11 reset value", pc_q, RV);
  endtask

  task automatic t_fields;
    drive(32'h40, mk_i(6'h05, 5'd19, 5'd6, 16'h1234));
    chk("R1 rs index", {27'd0, rs_idx}, 32'd19);
    chk("R1 rt index", {27'd0, rt_idx}, 32'd6);
  endtask

  task automatic t_seq;
    for (int op = 0; op < 64; op++) begin
      if (op >= 6'h20 && op <= 6'h2D) continue;
      if (op == 6'h2F) continue;
      drive(32'h0000_2000, mk_i(6'(op), 5'd1, 5'd2, 16'h0040));
      chk("R6 sequential next", next_pc, 32'h0000_2004);
      chk("R6 taken low", {31'd0, taken}, 32'd0);
      chk("R7 flag low", {31'd0, unres}, 32'd0);
    end
  endtask

  task automatic t_branch;
    logic [31:0] av [4] = '{32'd5, 32'hFFFF_FFFF, 32'd1, 32'd3};
    logic [31:0] bv [4] = '{32'd5, 32'd1, 32'hFFFF_FFFF, 32'd7};
    for (int p = 0; p < 4; p++) begin
      regs[1] = av[p];
      regs[2] = bv[p];
      for (int c = 0; c < 10; c++) begin
        logic h;
        h = ref_cond(c, av[p], bv[p]);
        drive(32'h0000_1000, mk_i(6'(32 + c), 5'd1, 5'd2, 16'hFFFE));
        chk("R2 R3 branch next", next_pc, h ? 32'h0000_0FFC : 32'h0000_1004);
        chk("R9 branch taken", {31'd0, taken}, {31'd0, h});
      end
    end
    regs[1] = 32'd9;
    regs[2] = 32'd9;
    drive(32'h0000_1000, mk_i(6'h20, 5'd1, 5'd2, 16'h0010));
    chk("R3 forward target", next_pc, 32'h0000_1044);
  endtask

  task automatic t_jumps;
    drive(32'h0000_2000, mk_j(6'h2A, 26'h3FF_FFFF));
    chk("R4 backward rel", next_pc, 32'h0000_2000);
    chk("R9 rel taken", {31'd0, taken}, 32'd1);
    drive(32'h0000_2000, mk_j(6'h2C, 26'h000_0100));
    chk("R4 forward rel", next_pc, 32'h0000_2404);
    regs[3] = 32'h1234_5677;
    drive(32'h0000_2000, mk_i(6'h2B, 5'd3, 5'd0, 16'h0));
    chk("R5 reg jump", next_pc, 32'h1234_5674);
    regs[3] = 32'h8000_0003;
    drive(32'h0000_2000, mk_i(6'h2D, 5'd3, 5'd0, 16'h0));
    chk("R5 reg jump 2", next_pc, 32'h8000_0000);
    chk("R9 reg taken", {31'd0, taken}, 32'd1);
  endtask

  task automatic t_stop;
    drive(32'h0000_3000, mk_i(6'h2F, 5'd1, 5'd2, 16'h0100));
    chk("R7 flag high", {31'd0, unres}, 32'd1);
    chk("R7 next held", next_pc, 32'h0000_3004);
    chk("R7 taken low", {31'd0, taken}, 32'd0);
  endtask

  task automatic t_zero;
    regs[0] = 32'hDEAD_BEEF;
    regs[5] = 32'd0;
    drive(32'h0000_4000, mk_i(6'h2B, 5'd0, 5'd0, 16'h0));
    chk("R8 zero reg jump", next_pc, 32'h0000_0000);
    drive(32'h0000_4000, mk_i(6'h20, 5'd0, 5'd5, 16'h0004));
    chk("R8 zero eq branch", next_pc, 32'h0000_4014);
    drive(32'h0000_4000, mk_i(6'h21, 5'd5, 5'd0, 16'h0004));
    chk("R8 zero ne branch", next_pc, 32'h0000_4004);
  endtask

  task automatic t_wrap;
    drive(32'hFFFF_FFFC, mk_i(6'h00, 5'd0, 5'd0, 16'h0));
    chk("R10 seq wrap", next_pc, 32'h0000_0000);
    regs[1] = 32'd1;
    regs[2] = 32'd1;
    drive(32'hFFFF_FFF0, mk_i(6'h20, 5'd1, 5'd2, 16'h0010));
    chk("R10 branch wrap", next_pc, 32'h0000_0034);
    drive(32'h0000_0000, mk_j(6'h2A, 26'h3FF_FFFE));
    chk("R10 rel wrap", next_pc, 32'hFFFF_FFFC);
  endtask

  task automatic t_reg;
    drive(32'h0000_5000, mk_i(6'h00, 5'd0, 5'd0, 16'h0));
    advance = 1'b0;
    @(posedge clk);
    #1;
    chk("R11 hold", pc_q, RV);
    @(negedge clk);
    advance = 1'b1;
    @(posedge clk);
    #1;
    chk("R11 load", pc_q, 32'h0000_5004);
    @(negedge clk);
    advance = 1'b0;
    pc = 32'h0000_7000;
    @(posedge clk);
    #1;
    chk("R11 hold after load", pc_q, 32'h0000_5004);
    @(negedge clk);
    #1;
    rst_n = 1'b0;
    #0.5;
    chk("R11 async reset", pc_q, RV);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0;
    advance = 1'b0;
    pc = '0;
    instr = '0;
    for (int k = 0; k < 32; k++) regs[k] = 32'(k) * 32'h0101_0101;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_fields();
    t_seq();
    t_branch();
    t_jumps();
    t_stop();
    t_zero();
    t_wrap();
    t_reg();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule